// File: doc/BRIEF.md
# Start-Flagged Serial Input Capture Register

This block samples one serial data pin into a 28-bit capture word for a processor's general-purpose input port. Sampling runs only while the shift input mode is selected. Once that mode is on, the block takes one sample per divided period of the core clock, with no further enable. Each sample moves the word up by one place. The new bit enters at bit 0, and the bit that was in bit 27 is lost. The word never stalls and never reports an error when it fills.

A sticky start flag records the first logic one that the block captures. A saturating counter reports how many samples have been taken since that flag was set, counting the one-bit that set it. Software reads the word, the flag and the count directly. A one-cycle clear zeroes all three together. Leaving shift mode freezes all three values. Entering shift mode again continues from the frozen values and does not clear them.

Top module: `serial_start_capture`

## Requirements
- R1: While `rst_n` is low at a rising edge, the capture word, the start flag, the bit count and the divider phase all become zero on that edge.
- R2: In shift mode with divide ratio N held constant, `sample_pulse` is high for one cycle in every N+1 cycles. With N=0 it is high on every cycle. Outside shift mode it is low.
- R3: At each edge where `sample_pulse` is high and `clear_req` is low, `cap_word` becomes {previous bits 26:0, `ser_in`}, so the newest sample is at bit 0.
- R4: After more than 28 samples, the oldest bits are dropped off bit 27 and sampling carries on at the same rate, with no stall.
- R5: `start_seen` goes to 1 on the first sample that captures a 1. Samples of 0 never set it. It stays at 1 until a clear, even after that one-bit has been shifted out of the word.
- R6: `bit_count` is 0 while `start_seen` is 0. It becomes 1 on the sample that sets the flag, rises by one with each later sample, and holds at 28.
- R7: When `clear_req` is high at an edge, the word, the flag and the count are zero after that edge, and any sample taken at the same edge is discarded. The divider phase is not affected.
- R8: While shift mode is off, the word, the flag and the count hold their values and the divider phase is zero. On re-entry, shifting resumes from the held values, and the first sample comes N+1 cycles after the mode goes high.
- R9: If the ratio is lowered to a value at or below the current divider phase, a sample is taken on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_mode | input | 1 | 1 selects the serial shift input mode |
| div_ratio | input | 8 | Divide ratio N. The sample period is N+1 core cycles |
| clear_req | input | 1 | One-cycle clear of the word, the flag and the count |
| ser_in | input | 1 | Serial data pin, already synchronous to `clk` |
| cap_word | output | 28 | Captured word, newest bit in bit 0 |
| start_seen | output | 1 | Sticky flag for the first captured one-bit |
| bit_count | output | 5 | Samples taken since the flag was set, saturating at 28 |
| sample_pulse | output | 1 | High during a cycle whose closing edge takes a sample |

## Verification
Two cases are the hardest to reach from the ports. The first is a ratio change that lands below the running phase. To reach it, the stimulus lets a large ratio run for many cycles and then drops the ratio to a small value mid-period. The second is a clear that falls on the same edge as a sample. The stimulus places it by waiting until `sample_pulse` is seen high. Saturation and loss of the start bit need long runs of ones behind a leading one, so the bench feeds more than 28 samples after the flag is set. The bench also leaves shift mode mid-period and later re-enters it, to show that the word is held and the divider phase restarts from zero.

// File: rtl/serial_capture_pkg.sv
// Package: serial_capture_pkg
// Holds the shared sizes for the serial capture block. Every module takes its
// widths from here by default, so a change stays consistent across the block.
package serial_capture_pkg;
    // width of the capture word
    parameter int unsigned CAP_BITS = 28;
    // width of the divide ratio
    parameter int unsigned DIV_BITS = 8;
    // width needed to hold a count from 0 to CAP_BITS
    parameter int unsigned CNT_BITS = $clog2(CAP_BITS + 1);
endpackage : serial_capture_pkg

// File: rtl/sample_divider.sv
// Module: sample_divider
// Makes the sample strobe. It counts core cycles while shift mode is on and
// raises the strobe when the phase reaches the divide ratio, so the sample
// period is ratio+1 cycles. The phase is held at zero outside shift mode.
// The >= compare means a ratio lowered below the running phase fires at once.
// Assumes: synchronous active-low reset, and a ratio that the caller holds
// steady except for deliberate changes.
module sample_divider #(
    parameter int unsigned DIV_W = serial_capture_pkg::DIV_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_on,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] phase_d;

    // strobe when the running phase has reached the programmed ratio
    always_comb begin
        tick = mode_on && (phase_q >= ratio);
    end

    // next phase: zero when idle or after a strobe, otherwise count up
    always_comb begin
        if (!mode_on) begin
            phase_d = '0;
        end else if (tick) begin
            phase_d = '0;
        end else begin
            phase_d = phase_q + 1'b1;
        end
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    // R2: with a nonzero ratio, two strobes never fall on back-to-back cycles
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || ratio == '0));

    // R8: the phase is zero one cycle after the mode is off
    assert_idle_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |=> (phase_q == '0));
endmodule : sample_divider

// File: rtl/capture_shifter.sv
// Module: capture_shifter
// Holds the capture word and the sticky start flag. On each strobe the word
// moves up one place and the pin value enters bit 0. The top bit is dropped.
// The first captured one-bit sets the flag, which stays set until a clear.
// A clear overrides a coincident strobe.
// Assumes: the pin is already synchronous to clk.
module capture_shifter #(
    parameter int unsigned WIDTH = serial_capture_pkg::CAP_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic             pin,
    output logic [WIDTH-1:0] word,
    output logic             flag,
    output logic             flag_set
);
    logic [WIDTH-1:0] word_q;
    logic             flag_q;

    // one register cell per bit: bit 0 takes the pin, bit i takes bit i-1
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        logic src;
        // choose the value that moves into this cell on a strobe
        always_comb begin
            if (gi == 0) begin
                src = pin;
            end else begin
                src = word_q[(gi == 0) ? 0 : gi-1];
            end
        end
        // per-bit register: clear, then shift on strobe, else hold
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                word_q[gi] <= 1'b0;
            end else if (tick) begin
                word_q[gi] <= src;
            end
        end
    end

    // pulse on the sample that sets the flag for the first time
    always_comb begin
        flag_set = tick && pin && !flag_q && !clear;
    end

    // sticky start flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            flag_q <= 1'b0;
        end else if (flag_set) begin
            flag_q <= 1'b1;
        end
    end

    assign word = word_q;
    assign flag = flag_q;

    // R3: the word moves up by one and takes the pin into bit 0 on a strobe
    assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> (word_q == {$past(word_q[WIDTH-2:0]), $past(pin)}));

    // R8: without a strobe or a clear the word holds
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(word_q));

    // R5: the flag stays set until a clear
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clear) |=> flag_q);

    // R5: the flag rises only from a sampled one-bit
    assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(tick) && $past(pin)));
endmodule : capture_shifter

// File: rtl/start_bit_counter.sv
// Module: start_bit_counter
// Counts the samples taken since the start flag was set. The sample that sets
// the flag loads one. Each later strobe adds one, and the count holds at LIMIT.
// A clear zeroes it.
// Assumes: flag_set and flag come from the shifter in the same cycle domain.
module start_bit_counter #(
    parameter int unsigned LIMIT = serial_capture_pkg::CAP_BITS,
    parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic             flag,
    input  logic             flag_set,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CAP_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // saturating sample counter gated by the start flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (flag_set) begin
            cnt_q <= CNT_W'(1);
        end else if (tick && flag && cnt_q != CAP_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

    // R6: the count never exceeds the word width
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP_MAX);

    // R6: once saturated, the count holds until a clear
    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CAP_MAX && !clear) |=> (cnt_q == CAP_MAX));
endmodule : start_bit_counter

// File: rtl/serial_start_capture.sv
// Module: serial_start_capture (top)
// A 28-bit serial input capture register with a programmable sample divider,
// a sticky start flag, a saturating bit count and a one-cycle clear.
// Assumes: ser_in is synchronous to clk, and rst_n is synchronous and
// active low.
module serial_start_capture #(
    parameter int unsigned CAP_W = serial_capture_pkg::CAP_BITS,
    parameter int unsigned DIV_W = serial_capture_pkg::DIV_BITS,
    localparam int unsigned CNT_W = $clog2(CAP_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_mode,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic             clear_req,
    input  logic             ser_in,
    output logic [CAP_W-1:0] cap_word,
    output logic             start_seen,
    output logic [CNT_W-1:0] bit_count,
    output logic             sample_pulse
);
    logic tick;
    logic flag;
    logic flag_set;

    sample_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_on (shift_mode),
        .ratio   (div_ratio),
        .tick    (tick)
    );

    capture_shifter #(.WIDTH(CAP_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (clear_req),
        .pin      (ser_in),
        .word     (cap_word),
        .flag     (flag),
        .flag_set (flag_set)
    );

    start_bit_counter #(.LIMIT(CAP_W), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (clear_req),
        .flag     (flag),
        .flag_set (flag_set),
        .count    (bit_count)
    );

    assign start_seen   = flag;
    assign sample_pulse = tick;

    // R7: a clear empties the word, the flag and the count on its edge
    assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (cap_word == '0 && !start_seen && bit_count == '0));

    // R6: the count is nonzero exactly when the flag is set
    assert_count_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_count != '0) == start_seen);

    // R2: no sample is taken outside shift mode
    assert_no_idle_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_mode |-> !sample_pulse);
endmodule : serial_start_capture

// File: tb/serial_start_capture_test.sv
// Bench for serial_start_capture. A behavioural model built from a bit queue
// and integers is compared with the outputs on every falling edge.
module serial_start_capture_test;
    localparam int W = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_mode = 1'b0;
    logic [7:0]  div_ratio = 8'd0;
    logic        clear_req = 1'b0;
    logic        ser_in = 1'b0;
    logic [27:0] cap_word;
    logic        start_seen;
    logic [4:0]  bit_count;
    logic        sample_pulse;

    int vectors = 0;
    int misses  = 0;
    bit live    = 1'b0;
    bit done    = 1'b0;

    // model state
    bit q[$];
    int m_phase = 0;
    bit m_flag  = 1'b0;
    int m_cnt   = 0;
    logic [31:0] lfsr = 32'hACE1_1234;

    serial_start_capture uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_mode   (shift_mode),
        .div_ratio    (div_ratio),
        .clear_req    (clear_req),
        .ser_in       (ser_in),
        .cap_word     (cap_word),
        .start_seen   (start_seen),
        .bit_count    (bit_count),
        .sample_pulse (sample_pulse)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [27:0] model_word();
        logic [27:0] w = '0;
        for (int i = 0; i < q.size(); i++) w[q.size()-1-i] = q[i];
        return w;
    endfunction

    function automatic bit model_pulse();
        return shift_mode && (m_phase >= int'(div_ratio));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // reference model: advances on each rising edge from the applied inputs
    always @(posedge clk) begin
        bit t;
        if (!rst_n) begin
            q.delete(); m_phase = 0; m_flag = 1'b0; m_cnt = 0; live = 1'b1;
        end else begin
            t = model_pulse();
            if (!shift_mode || t) m_phase = 0; else m_phase++;
            if (clear_req) begin
                q.delete(); m_flag = 1'b0; m_cnt = 0;
            end else if (t) begin
                q.push_back(ser_in);
                if (q.size() > W) void'(q.pop_front());
                if (m_flag) begin
                    if (m_cnt < W) m_cnt++;
                end else if (ser_in) begin
                    m_flag = 1'b1; m_cnt = 1;
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (live && !done) begin
            check("R3 R4 word", 32'(cap_word), 32'(model_word()));
            check("R5 flag", 32'(start_seen), 32'(m_flag));
            check("R6 count", 32'(bit_count), 32'(m_cnt));
            check("R2 R9 pulse", 32'(sample_pulse), 32'(model_pulse()));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rand_bits(input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ser_in = lfsr[0];
            step(1);
        end
    endtask

    initial begin
        logic [27:0] held;
        step(3);
        @(negedge clk);
        check("R1 reset word", 32'(cap_word), 32'd0);
        check("R1 reset flag", 32'(start_seen), 32'd0);
        check("R1 reset count", 32'(bit_count), 32'd0);
        step(1);
        rst_n = 1'b1;
        // R5: zeros alone never set the flag
        shift_mode = 1'b1; div_ratio = 8'd0; ser_in = 1'b0;
        step(12);
        @(negedge clk);
        check("R5 zeros only", 32'(start_seen), 32'd0);
        step(1);
        rand_bits(50);
        // R4: more than 28 samples of ones after a leading one; R6 saturation
        ser_in = 1'b1; step(40);
        @(negedge clk);
        check("R4 full word", 32'(cap_word), 32'h0FFF_FFFF);
        check("R6 saturate", 32'(bit_count), 32'd28);
        step(1);
        // R5: start bit shifted out by zeros; flag stays
        ser_in = 1'b0; step(35);
        @(negedge clk);
        check("R5 sticky", 32'(start_seen), 32'd1);
        check("R4 drained", 32'(cap_word), 32'd0);
        step(1);
        // ratio 3 with random data
        div_ratio = 8'd3; rand_bits(80);
        // R7: clear coincident with a sample
        while (!sample_pulse) step(1);
        clear_req = 1'b1; ser_in = 1'b1; step(1);
        clear_req = 1'b0;
        @(negedge clk);
        check("R7 clear word", 32'(cap_word), 32'd0);
        check("R7 clear flag", 32'(start_seen), 32'd0);
        step(1);
        rand_bits(40);
        // R8: leave mode mid-period, word held with toggling pin
        step(1);
        shift_mode = 1'b0; held = cap_word;
        rand_bits(20);
        @(negedge clk);
        check("R8 frozen", 32'(cap_word), 32'(held));
        step(1);
        shift_mode = 1'b1; rand_bits(30);
        // R9: large ratio, then drop below the phase
        div_ratio = 8'd200; rand_bits(300);
        while (sample_pulse) step(1);
        step(150);
        div_ratio = 8'd2;
        @(negedge clk);
        check("R9 early sample", 32'(sample_pulse), 32'd1);
        step(1);
        div_ratio = 8'd1; rand_bits(100);
        step(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            vectors++; misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule : serial_start_capture_test